// File: doc/BRIEF.md
# Key-Guarded Event Counter Bank

This block holds a small bank of event counters and screens every request made to them against secrets kept for each counter. Each counter owns an owner key, a use key, a per-ring block mask and an enable bit. A request names a counter, an operation, an optional key and the privilege ring of the requester. The block either carries the request out or rejects it, and it answers one clock later with a fault flag and, for a granted read, the counter value.

A requester that has no key sets the legacy flag. The block then compares a fixed default key in place of the presented one. After reset both keys of every counter equal that default, so legacy software can read, load and enable any counter with no setup. An owner claims a counter with its first set-key request. It can then make the use key equal to its own secret, which locks out default-key users, and it can mask whole privilege rings. Software tests whether a counter can be locked by attempting that set-key and watching the fault flag.

Top module: `ctr_key_guard`

## Requirements
- R1: After reset every counter reads zero with its enable clear, its ring mask clear, and both of its keys equal to the default key 48'h000000000ACE. A legacy request is then granted on any counter.
- R2: When req_legacy_i is 1, the block ignores req_key_i and compares the default key in its place.
- R3: The operations are read (op 0), write (op 1), program (op 2) and set-key (op 3). Read, write and program are granted only when the effective key equals the counter's use key. A granted read returns the counter value. A granted write loads req_wdata_i. A granted program sets the enable bit to req_wdata_i[0].
- R4: Set-key is granted when the effective key equals the counter's owner key. req_sel_i picks the target: 0 = use key, 1 = owner key, 2 = ring mask. Keys are loaded from req_wdata_i[47:0] and the mask from req_wdata_i[3:0]. req_sel_i = 3 is rejected.
- R5: A set-key on a counter whose owner key still equals the default key is granted whatever key is presented, and it claims the counter. The effective key becomes the new owner key, unless the request itself writes the owner key (select 1), in which case the written value is stored.
- R6: Setting the use key equal to the owner secret makes legacy requests fault. Setting the use key back to the default key makes them succeed again.
- R7: When bit r of a counter's ring mask is set, read, write and program from ring r fault even with the correct key. Set-key requests are not affected by the mask.
- R8: A rejected request changes no key, mask, enable or counter value. Its response has rsp_fault_o high for exactly one cycle and rsp_rdata_o equal to zero.
- R9: Every request presented with req_valid_i high gets rsp_valid_o high on the next cycle. rsp_rdata_o is zero for every response other than a granted read.
- R10: A counter whose enable bit is set increments by one on each cycle its event_i bit is high, wrapping from all ones to zero. With the enable bit clear, the counter holds its value.
- R11: When a granted write and an increment hit the same counter in the same cycle, the written value is stored and the increment is lost.
- R12: Once a counter has been claimed, a set-key attempt made with any key other than the owner key faults, so a second party can tell that the counter cannot be locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 2 | Operation: 0 read, 1 write, 2 program, 3 set-key |
| req_ctr_i | input | 2 | Counter index |
| req_sel_i | input | 2 | Set-key target: 0 use key, 1 owner key, 2 ring mask |
| req_legacy_i | input | 1 | No key presented; use the default key |
| req_key_i | input | 48 | Presented key |
| req_ring_i | input | 2 | Privilege ring of the requester |
| req_wdata_i | input | 48 | Write data, new key, mask or enable |
| event_i | input | 4 | One event strobe per counter |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_fault_o | output | 1 | Request was rejected |
| rsp_rdata_o | output | 48 | Counter value for a granted read, else zero |

## Verification
A granted write to a counter and an event increment on that same counter can land on one clock edge. The bench provokes this by raising the counter's event bit in the same cycle it presents a keyed write, with the enable bit already set. It then reads the counter back and expects exactly the written value, with no extra count. It also runs event bursts and a wrap from all ones, so that the increment path is shown to work when no write competes with it.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
  localparam logic [1:0] OP_READ   = 2'd0;
  localparam logic [1:0] OP_WRITE  = 2'd1;
  localparam logic [1:0] OP_PROG   = 2'd2;
  localparam logic [1:0] OP_SETKEY = 2'd3;

  localparam logic [1:0] SEL_USE   = 2'd0;
  localparam logic [1:0] SEL_OWNER = 2'd1;
  localparam logic [1:0] SEL_RING  = 2'd2;
endpackage

// File: rtl/ckg_slot.sv
module ckg_slot #(
  parameter int CTR_W = 48,
  parameter int KEY_W = 48,
  parameter int NUM_RINGS = 4,
  parameter logic [KEY_W-1:0] DEFAULT_KEY = '0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 event_i,
  input  logic                 cnt_we_i,
  input  logic [CTR_W-1:0]     cnt_d_i,
  input  logic                 en_we_i,
  input  logic                 en_d_i,
  input  logic                 use_we_i,
  input  logic [KEY_W-1:0]     use_d_i,
  input  logic                 own_we_i,
  input  logic [KEY_W-1:0]     own_d_i,
  input  logic                 ring_we_i,
  input  logic [NUM_RINGS-1:0] ring_d_i,
  output logic [CTR_W-1:0]     cnt_o,
  output logic                 en_o,
  output logic [KEY_W-1:0]     use_key_o,
  output logic [KEY_W-1:0]     own_key_o,
  output logic [NUM_RINGS-1:0] ring_blk_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (cnt_we_i) begin
      cnt_o <= cnt_d_i;              // load beats increment
    end else if (en_o && event_i) begin
      cnt_o <= cnt_o + CTR_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o       <= 1'b0;
      use_key_o  <= DEFAULT_KEY;
      own_key_o  <= DEFAULT_KEY;
      ring_blk_o <= '0;
    end else begin
      if (en_we_i)   en_o       <= en_d_i;
      if (use_we_i)  use_key_o  <= use_d_i;
      if (own_we_i)  own_key_o  <= own_d_i;
      if (ring_we_i) ring_blk_o <= ring_d_i;
    end
  end

endmodule

// File: rtl/ckg_auth.sv
module ckg_auth
  import ckg_pkg::*;
#(
  parameter int KEY_W = 48,
  parameter int NUM_RINGS = 4,
  parameter logic [KEY_W-1:0] DEFAULT_KEY = '0,
  localparam int RING_W = $clog2(NUM_RINGS)
) (
  input  logic                 valid_i,
  input  logic [1:0]           op_i,
  input  logic [1:0]           sel_i,
  input  logic                 legacy_i,
  input  logic [KEY_W-1:0]     key_i,
  input  logic [RING_W-1:0]    ring_i,
  input  logic [KEY_W-1:0]     new_key_i,
  input  logic [KEY_W-1:0]     use_key_i,
  input  logic [KEY_W-1:0]     own_key_i,
  input  logic [NUM_RINGS-1:0] ring_blk_i,
  output logic                 fault_o,
  output logic                 rd_en_o,
  output logic                 cnt_we_o,
  output logic                 en_we_o,
  output logic                 use_we_o,
  output logic                 own_we_o,
  output logic [KEY_W-1:0]     own_d_o,
  output logic                 ring_we_o
);

  logic [KEY_W-1:0] eff_key;
  logic use_ok, unclaimed, own_ok, sel_ok, is_set, grant, set_ok, claim;

  assign eff_key   = legacy_i ? DEFAULT_KEY : key_i;
  assign use_ok    = (eff_key == use_key_i) && !ring_blk_i[ring_i];
  assign unclaimed = (own_key_i == DEFAULT_KEY);
  assign own_ok    = unclaimed || (eff_key == own_key_i);
  assign sel_ok    = (sel_i != 2'd3);
  assign is_set    = (op_i == OP_SETKEY);

  always_comb begin
    grant = 1'b0;
    if (valid_i) begin
      if (is_set) grant = own_ok && sel_ok;
      else        grant = use_ok;
    end
  end

  assign set_ok    = grant && is_set;
  assign claim     = set_ok && unclaimed;
  assign fault_o   = valid_i && !grant;
  assign rd_en_o   = grant && (op_i == OP_READ);
  assign cnt_we_o  = grant && (op_i == OP_WRITE);
  assign en_we_o   = grant && (op_i == OP_PROG);
  assign use_we_o  = set_ok && (sel_i == SEL_USE);
  assign ring_we_o = set_ok && (sel_i == SEL_RING);
  assign own_we_o  = set_ok && ((sel_i == SEL_OWNER) || claim);
  assign own_d_o   = (sel_i == SEL_OWNER) ? new_key_i : eff_key;

endmodule

// File: rtl/ckg_rsp.sv
module ckg_rsp #(
  parameter int CTR_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             fault_i,
  input  logic             rd_en_i,
  input  logic [CTR_W-1:0] cnt_i,
  output logic             valid_o,
  output logic             fault_o,
  output logic [CTR_W-1:0] rdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      fault_o <= 1'b0;
      rdata_o <= '0;
    end else begin
      valid_o <= valid_i;
      fault_o <= fault_i;
      rdata_o <= rd_en_i ? cnt_i : '0;
    end
  end

endmodule

// File: rtl/ctr_key_guard.sv
module ctr_key_guard #(
  parameter int NUM_CTR = 4,
  parameter int CTR_W = 48,
  parameter int KEY_W = 48,
  parameter int NUM_RINGS = 4,
  parameter logic [KEY_W-1:0] DEFAULT_KEY = 48'h0000_0000_0ACE,
  localparam int IDX_W = $clog2(NUM_CTR),
  localparam int RING_W = $clog2(NUM_RINGS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [1:0]         req_op_i,
  input  logic [IDX_W-1:0]   req_ctr_i,
  input  logic [1:0]         req_sel_i,
  input  logic               req_legacy_i,
  input  logic [KEY_W-1:0]   req_key_i,
  input  logic [RING_W-1:0]  req_ring_i,
  input  logic [CTR_W-1:0]   req_wdata_i,
  input  logic [NUM_CTR-1:0] event_i,
  output logic               rsp_valid_o,
  output logic               rsp_fault_o,
  output logic [CTR_W-1:0]   rsp_rdata_o
);

  logic [NUM_CTR-1:0][CTR_W-1:0]     cnt_q;
  logic [NUM_CTR-1:0]                en_q;
  logic [NUM_CTR-1:0][KEY_W-1:0]     use_q;
  logic [NUM_CTR-1:0][KEY_W-1:0]     own_q;
  logic [NUM_CTR-1:0][NUM_RINGS-1:0] ring_q;
  logic [NUM_CTR-1:0]                hit;
  logic [NUM_CTR-1:0]                cnt_we_vec;

  logic             fault, rd_en, cnt_we, en_we, use_we, own_we, ring_we;
  logic [KEY_W-1:0] own_d;

  ckg_auth #(
    .KEY_W(KEY_W), .NUM_RINGS(NUM_RINGS), .DEFAULT_KEY(DEFAULT_KEY)
  ) u_auth (
    .valid_i    (req_valid_i),
    .op_i       (req_op_i),
    .sel_i      (req_sel_i),
    .legacy_i   (req_legacy_i),
    .key_i      (req_key_i),
    .ring_i     (req_ring_i),
    .new_key_i  (req_wdata_i[KEY_W-1:0]),
    .use_key_i  (use_q[req_ctr_i]),
    .own_key_i  (own_q[req_ctr_i]),
    .ring_blk_i (ring_q[req_ctr_i]),
    .fault_o    (fault),
    .rd_en_o    (rd_en),
    .cnt_we_o   (cnt_we),
    .en_we_o    (en_we),
    .use_we_o   (use_we),
    .own_we_o   (own_we),
    .own_d_o    (own_d),
    .ring_we_o  (ring_we)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_slot
    assign hit[i]        = (req_ctr_i == IDX_W'(i));
    assign cnt_we_vec[i] = hit[i] && cnt_we;

    ckg_slot #(
      .CTR_W(CTR_W), .KEY_W(KEY_W), .NUM_RINGS(NUM_RINGS), .DEFAULT_KEY(DEFAULT_KEY)
    ) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .event_i    (event_i[i]),
      .cnt_we_i   (cnt_we_vec[i]),
      .cnt_d_i    (req_wdata_i),
      .en_we_i    (hit[i] && en_we),
      .en_d_i     (req_wdata_i[0]),
      .use_we_i   (hit[i] && use_we),
      .use_d_i    (req_wdata_i[KEY_W-1:0]),
      .own_we_i   (hit[i] && own_we),
      .own_d_i    (own_d),
      .ring_we_i  (hit[i] && ring_we),
      .ring_d_i   (req_wdata_i[NUM_RINGS-1:0]),
      .cnt_o      (cnt_q[i]),
      .en_o       (en_q[i]),
      .use_key_o  (use_q[i]),
      .own_key_o  (own_q[i]),
      .ring_blk_o (ring_q[i])
    );
  end

  ckg_rsp #(.CTR_W(CTR_W)) u_rsp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (req_valid_i),
    .fault_i (fault),
    .rd_en_i (rd_en),
    .cnt_i   (cnt_q[req_ctr_i]),
    .valid_o (rsp_valid_o),
    .fault_o (rsp_fault_o),
    .rdata_o (rsp_rdata_o)
  );

endmodule

// File: rtl/ctr_key_guard_chk.sv
module ctr_key_guard_chk
  import ckg_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CTR_W = 48,
  parameter int KEY_W = 48,
  parameter int NUM_RINGS = 4
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic                              req_valid_i,
  input logic [1:0]                        req_op_i,
  input logic [CTR_W-1:0]                  req_wdata_i,
  input logic                              rsp_valid_o,
  input logic                              rsp_fault_o,
  input logic [CTR_W-1:0]                  rsp_rdata_o,
  input logic [NUM_CTR-1:0][CTR_W-1:0]     cnt_q,
  input logic [NUM_CTR-1:0]                en_q,
  input logic [NUM_CTR-1:0][KEY_W-1:0]     use_q,
  input logic [NUM_CTR-1:0][KEY_W-1:0]     own_q,
  input logic [NUM_CTR-1:0][NUM_RINGS-1:0] ring_q,
  input logic [NUM_CTR-1:0]                cnt_we_vec
);

  assert_rsp_follows_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_no_rsp_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  assert_fault_zero_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> (rsp_valid_o && rsp_rdata_o == '0));

  assert_fault_keeps_state_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> ($stable(use_q) && $stable(own_q) && $stable(ring_q) && $stable(en_q)));

  assert_owner_via_setkey_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(own_q) |-> $past(req_valid_i && req_op_i == OP_SETKEY));

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(!en_q[i]) && $past(!cnt_we_vec[i])) |-> $stable(cnt_q[i]));

    assert_write_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(cnt_we_vec[i]) |-> (cnt_q[i] == $past(req_wdata_i)));
  end

endmodule

bind ctr_key_guard ctr_key_guard_chk #(
  .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .KEY_W(KEY_W), .NUM_RINGS(NUM_RINGS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_op_i    (req_op_i),
  .req_wdata_i (req_wdata_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_fault_o (rsp_fault_o),
  .rsp_rdata_o (rsp_rdata_o),
  .cnt_q       (cnt_q),
  .en_q        (en_q),
  .use_q       (use_q),
  .own_q       (own_q),
  .ring_q      (ring_q),
  .cnt_we_vec  (cnt_we_vec)
);

// File: tb/ctr_key_guard_tb_top.sv
`timescale 1ns/1ps
module ctr_key_guard_tb_top;

  localparam logic [47:0] KD = 48'h0000_0000_0ACE;
  localparam logic [47:0] KM = 48'h1234_5678_9ABC;
  localparam logic [47:0] KA = 48'h0F0F_F0F0_AAAA;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  ctr;
    logic [1:0]  sel;
    logic        leg;
    logic [47:0] key;
    logic [1:0]  ring;
    logic [47:0] wdata;
    logic        fault;
    logic [47:0] rdata;
    logic [7:0]  req;
  } vec_t;

  // op: 0 rd, 1 wr, 2 prog, 3 setkey; sel: 0 use, 1 owner, 2 ring mask
  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 2'd0, 2'd0, 1'b1, 48'h0, 2'd0, 48'd77, 1'b0, 48'd0,  8'd2},  // R2 legacy write
    '{2'd0, 2'd0, 2'd0, 1'b1, 48'h0, 2'd0, 48'd0,  1'b0, 48'd77, 8'd3},  // R3 legacy read
    '{2'd0, 2'd0, 2'd0, 1'b0, KM,    2'd0, 48'd0,  1'b1, 48'd0,  8'd3},  // R3 wrong use key
    '{2'd3, 2'd0, 2'd0, 1'b0, KM,    2'd0, KM,     1'b0, 48'd0,  8'd5},  // R5 claim + lock
    '{2'd0, 2'd0, 2'd0, 1'b1, 48'h0, 2'd0, 48'd0,  1'b1, 48'd0,  8'd6},  // R6 locked legacy
    '{2'd0, 2'd0, 2'd0, 1'b0, KM,    2'd0, 48'd0,  1'b0, 48'd77, 8'd6},  // R6 owner reads
    '{2'd3, 2'd0, 2'd0, 1'b0, KA,    2'd0, KD,     1'b1, 48'd0,  8'd4},  // R4 wrong owner key
    '{2'd0, 2'd0, 2'd0, 1'b1, 48'h0, 2'd0, 48'd0,  1'b1, 48'd0,  8'd8},  // R8 still locked
    '{2'd3, 2'd0, 2'd0, 1'b0, KA,    2'd0, KA,     1'b1, 48'd0,  8'd12}, // R12 probe fails
    '{2'd3, 2'd0, 2'd2, 1'b0, KM,    2'd0, 48'h8,  1'b0, 48'd0,  8'd7},  // R7 mask ring 3
    '{2'd0, 2'd0, 2'd0, 1'b0, KM,    2'd3, 48'd0,  1'b1, 48'd0,  8'd7},  // R7 ring 3 blocked
    '{2'd0, 2'd0, 2'd0, 1'b0, KM,    2'd2, 48'd0,  1'b0, 48'd77, 8'd7},  // R7 ring 2 ok
    '{2'd1, 2'd0, 2'd0, 1'b0, KM,    2'd3, 48'd5,  1'b1, 48'd0,  8'd7},  // R7 blocked write
    '{2'd0, 2'd0, 2'd0, 1'b0, KM,    2'd0, 48'd0,  1'b0, 48'd77, 8'd8},  // R8 value kept
    '{2'd3, 2'd0, 2'd0, 1'b0, KM,    2'd3, KD,     1'b0, 48'd0,  8'd6},  // R6 unlock, R7 setkey from ring 3
    '{2'd0, 2'd0, 2'd0, 1'b1, 48'h0, 2'd0, 48'd0,  1'b0, 48'd77, 8'd6},  // R6 legacy back
    '{2'd0, 2'd0, 2'd0, 1'b1, 48'h0, 2'd3, 48'd0,  1'b1, 48'd0,  8'd7},  // R7 mask still set
    '{2'd3, 2'd0, 2'd1, 1'b0, KM,    2'd0, KA,     1'b0, 48'd0,  8'd4},  // R4 owner key -> KA
    '{2'd3, 2'd0, 2'd2, 1'b0, KM,    2'd0, 48'h0,  1'b1, 48'd0,  8'd4},  // R4 old owner key
    '{2'd3, 2'd0, 2'd2, 1'b0, KA,    2'd0, 48'h0,  1'b0, 48'd0,  8'd4},  // R4 new owner clears
    '{2'd0, 2'd0, 2'd0, 1'b1, 48'h0, 2'd3, 48'd0,  1'b0, 48'd77, 8'd7},  // R7 ring 3 open
    '{2'd3, 2'd2, 2'd3, 1'b1, 48'h0, 2'd0, KA,     1'b1, 48'd0,  8'd4},  // R4 select 3 bad
    '{2'd0, 2'd2, 2'd0, 1'b1, 48'h0, 2'd0, 48'd0,  1'b0, 48'd0,  8'd1},  // R1 fresh counter
    '{2'd1, 2'd3, 2'd0, 1'b0, KA,    2'd0, 48'd9,  1'b1, 48'd0,  8'd2},  // R2 keyed vs default
    '{2'd3, 2'd3, 2'd0, 1'b1, 48'h0, 2'd0, KA,     1'b0, 48'd0,  8'd5},  // R5 legacy claim
    '{2'd0, 2'd3, 2'd0, 1'b0, KA,    2'd0, 48'd0,  1'b0, 48'd0,  8'd3}   // R3 new use key
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_op_i = '0;
  logic [1:0]  req_ctr_i = '0;
  logic [1:0]  req_sel_i = '0;
  logic        req_legacy_i = 1'b0;
  logic [47:0] req_key_i = '0;
  logic [1:0]  req_ring_i = '0;
  logic [47:0] req_wdata_i = '0;
  logic [3:0]  event_i = '0;
  logic        rsp_valid_o, rsp_fault_o;
  logic [47:0] rsp_rdata_o;

  int n_chk = 0;
  int n_bad = 0;
  logic        got_valid, got_fault;
  logic [47:0] got_rdata;

  always #2.5 clk_i = ~clk_i;

  ctr_key_guard dut_i (.*);

  task automatic check(input string tag, input logic [48:0] act, input logic [48:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [1:0] ctr, input logic [1:0] sel,
                       input logic leg, input logic [47:0] key, input logic [1:0] ring,
                       input logic [47:0] wd, input logic [3:0] ev);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_op_i = op; req_ctr_i = ctr; req_sel_i = sel;
    req_legacy_i = leg; req_key_i = key; req_ring_i = ring; req_wdata_i = wd;
    event_i = ev;
    @(negedge clk_i);
    got_valid = rsp_valid_o; got_fault = rsp_fault_o; got_rdata = rsp_rdata_o;
    req_valid_i = 1'b0; event_i = '0;
  endtask

  task automatic burst(input logic [3:0] ev, input int n);
    @(negedge clk_i);
    event_i = ev;
    repeat (n) @(negedge clk_i);
    event_i = '0;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 outputs idle after reset
    check("R1 reset rsp", {rsp_valid_o, rsp_fault_o, rsp_rdata_o[46:0]}, 49'd0);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].op, VECS[i].ctr, VECS[i].sel, VECS[i].leg, VECS[i].key,
            VECS[i].ring, VECS[i].wdata, 4'b0);
      check($sformatf("R%0d vec %0d", VECS[i].req, i),
            {got_fault, got_rdata}, {VECS[i].fault, VECS[i].rdata});
      if (!got_valid) check($sformatf("R9 valid vec %0d", i), 49'd0, 49'd1);
    end

    // R8 fault pulse lasts one cycle
    issue(2'd0, 2'd3, 2'd0, 1'b1, 48'h0, 2'd0, 48'd0, 4'b0);
    check("R8 fault set", {48'd0, got_fault}, 49'd1);
    @(negedge clk_i);
    check("R8 fault one cycle", {47'd0, rsp_valid_o, rsp_fault_o}, 49'd0);

    // R10 counting with enable; disabled counter holds
    issue(2'd2, 2'd1, 2'd0, 1'b1, 48'h0, 2'd0, 48'd1, 4'b0);
    check("R3 program", {got_fault, got_rdata}, 49'd0);
    burst(4'b0110, 5);
    issue(2'd0, 2'd1, 2'd0, 1'b1, 48'h0, 2'd0, 48'd0, 4'b0);
    check("R10 enabled count", {got_fault, got_rdata}, {1'b0, 48'd5});
    issue(2'd0, 2'd2, 2'd0, 1'b1, 48'h0, 2'd0, 48'd0, 4'b0);
    check("R10 disabled hold", {got_fault, got_rdata}, {1'b0, 48'd0});

    // R11 write and increment on the same edge
    issue(2'd1, 2'd1, 2'd0, 1'b1, 48'h0, 2'd0, 48'd100, 4'b0010);
    issue(2'd0, 2'd1, 2'd0, 1'b1, 48'h0, 2'd0, 48'd0, 4'b0);
    check("R11 write wins", {got_fault, got_rdata}, {1'b0, 48'd100});

    // R10 wrap from all ones
    issue(2'd1, 2'd1, 2'd0, 1'b1, 48'h0, 2'd0, {48{1'b1}}, 4'b0);
    burst(4'b0010, 1);
    issue(2'd0, 2'd1, 2'd0, 1'b1, 48'h0, 2'd0, 48'd0, 4'b0);
    check("R10 wrap", {got_fault, got_rdata}, {1'b0, 48'd0});

    // R9 non-read grant returns zero data
    issue(2'd2, 2'd1, 2'd0, 1'b1, 48'h0, 2'd0, 48'd0, 4'b0);
    check("R9 prog data zero", {got_valid, got_fault, got_rdata[46:0]}, {1'b1, 48'd0});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule